// File: doc/BRIEF.md
# Stereo Sample Queue with Safe-Default Underflow

This block sits between a sample producer (a processor or a DMA channel) and a stereo converter. The producer writes 16-bit samples into two independent first-in first-out queues, one for the left channel and one for the right. Each queue has full and empty outputs, so the producer can throttle its writes. Each sample written is converted into the converter's offset-binary code when it is stored. A single format input says whether that sample is two's complement or plain unsigned.

The converter issues a sample request. On that request, each channel takes the oldest word from its queue. A channel whose queue is empty gets the contents of a writable default register instead. This keeps the converter on a known safe level, such as the midpoint, rather than on stale data. Sticky flags record dropped writes (overflow) and requests that found a queue empty (underflow). One clear input resets all of these flags.

A two-state sequencer presents the results. From state ST_IDLE, a request moves it to ST_PRESENT, where out_valid is high. In ST_PRESENT, another request keeps it in ST_PRESENT and delivers a fresh pair. If no request arrives, it returns to ST_IDLE.

Top module: `stereo_sample_buffer`

## Requirements
- R1: After reset both empty outputs are 1, both full outputs are 0, all four sticky flags are 0, out_valid is 0, and the default register and both sample outputs hold 0x8000.
- R2: A channel's full output is 1 exactly when its queue holds DEPTH (4) words, and its empty output is 1 exactly when it holds none. The two are never both 1.
- R3: A write to a full queue, with no request in the same cycle, is discarded. The queue contents stay unchanged, and that channel's sticky overflow flag reads 1 from the next cycle.
- R4: When req is 1 at a clock edge, out_valid is 1 after that edge. Each channel output then carries the oldest stored word of that channel, and successive requests return words in the order they were written.
- R5: A channel whose queue is empty at a request outputs the default register's value, with its per-channel default indicator set to 1. Its sticky underflow flag reads 1 from the next cycle.
- R6: The default register loads dflt_data when dflt_we is 1. It is sent to the outputs exactly as written, with no format conversion whatever fmt_signed is.
- R7: With fmt_signed = 1 at write time, the stored word has its bit 15 inverted, so 0x7FFF becomes 0xFFFF, 0x0000 becomes 0x8000 and 0x8000 becomes 0x0000. With fmt_signed = 0, the word is stored unchanged.
- R8: flag_clr = 1 clears all sticky flags at the next edge. An overflow or underflow event in the same cycle wins for its own flag.
- R9: A write to a full queue in the same cycle as a request is accepted, because the request frees one slot.
- R10: An edge with req = 0 drops out_valid, or keeps it low, and leaves both sample outputs and the default indicators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_left_en | input | 1 | Write strobe for the left queue |
| wr_left_data | input | 16 | Left sample to store |
| wr_right_en | input | 1 | Write strobe for the right queue |
| wr_right_data | input | 16 | Right sample to store |
| fmt_signed | input | 1 | 1: written samples are two's complement; 0: unsigned |
| dflt_we | input | 1 | Load strobe for the default register |
| dflt_data | input | 16 | New default word, in converter code |
| flag_clr | input | 1 | Clears all sticky flags |
| req | input | 1 | Converter sample request |
| out_valid | output | 1 | A fresh sample pair is on the outputs |
| out_left | output | 16 | Left sample to the converter |
| out_right | output | 16 | Right sample to the converter |
| out_left_dflt | output | 1 | Left output came from the default register |
| out_right_dflt | output | 1 | Right output came from the default register |
| left_full | output | 1 | Left queue full |
| left_empty | output | 1 | Left queue empty |
| right_full | output | 1 | Right queue full |
| right_empty | output | 1 | Right queue empty |
| ovf_left | output | 1 | Sticky left overflow |
| ovf_right | output | 1 | Sticky right overflow |
| unf_left | output | 1 | Sticky left underflow |
| unf_right | output | 1 | Sticky right underflow |

## Verification
The bench builds the block with its default parameters, DATA_W = 16 and DEPTH = 4. A shallow queue like this fills after four writes, so the full boundary, the dropped fifth write, and a write that coincides with a request are all reached in a handful of cycles. With DEPTH = 4, the read and write pointers also wrap within a short sequence, so first-in first-out order is checked across the wrap. The 16-bit width puts the sign bit at bit 15, which lets the bench drive the signed extremes 0x7FFF, 0x8000, 0x0000 and 0xFFFF directly.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int NUM_CH   = 2;
    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sbuf_fmt.sv
module sbuf_fmt #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              signed_sel,
    output logic [DATA_W-1:0] dout
);
    localparam int MSB = DATA_W - 1;

    // two's complement to offset binary: flip the sign bit
    always_comb begin
        dout      = din;
        dout[MSB] = din[MSB] ^ signed_sel;
    end
endmodule

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              full,
    output logic              empty,
    output logic              push_drop,
    output logic              pop_miss
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              push_ok, pop_ok;

    assign full   = (count == CAP);
    assign empty  = (count == '0);
    assign pop_ok = pop && !empty;
    // a simultaneous pop frees a slot for the incoming word
    assign push_ok   = push && (!full || pop_ok);
    assign push_drop = push && !push_ok;
    assign pop_miss  = pop && empty;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sbuf_flags.sv
module sbuf_flags #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [NUM_CH-1:0] set_ovf,
    input  logic [NUM_CH-1:0] set_unf,
    output logic [NUM_CH-1:0] ovf,
    output logic [NUM_CH-1:0] unf
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= '0;
            unf <= '0;
        end else begin
            // a new event outranks the clear for its own flag
            ovf <= set_ovf | (clr ? '0 : ovf);
            unf <= set_unf | (clr ? '0 : unf);
        end
    end
endmodule

// File: rtl/sbuf_seq.sv
module sbuf_seq
    import sbuf_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter logic [15:0] DFLT_RESET = 16'h8000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic                          dflt_we,
    input  logic [DATA_W-1:0]             dflt_din,
    input  logic [NUM_CH-1:0][DATA_W-1:0] head,
    input  logic [NUM_CH-1:0]             empty,
    output logic [NUM_CH-1:0]             pop,
    output logic                          out_valid,
    output logic [NUM_CH-1:0][DATA_W-1:0] out_data,
    output logic [NUM_CH-1:0]             out_dflt
);
    localparam logic [DATA_W-1:0] DFLT_INIT = DATA_W'(DFLT_RESET);

    seq_state_e        state, state_nx;
    logic [DATA_W-1:0] dflt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req)  state_nx = ST_PRESENT;
            ST_PRESENT: if (!req) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
        pop = {NUM_CH{req}};
    end

    assign out_valid = (state == ST_PRESENT);

    always_ff @(posedge clk) begin
        if (!rst_n)       dflt_q <= DFLT_INIT;
        else if (dflt_we) dflt_q <= dflt_din;
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_out
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_data[c] <= DFLT_INIT;
                    out_dflt[c] <= 1'b0;
                end else if (req) begin
                    out_data[c] <= empty[c] ? dflt_q : head[c];
                    out_dflt[c] <= empty[c];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/stereo_sample_buffer.sv
module stereo_sample_buffer
    import sbuf_pkg::*;
#(
    parameter int          DATA_W     = 16,
    parameter int          DEPTH      = 4,
    parameter logic [15:0] DFLT_RESET = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_left_en,
    input  logic [DATA_W-1:0] wr_left_data,
    input  logic              wr_right_en,
    input  logic [DATA_W-1:0] wr_right_data,
    input  logic              fmt_signed,
    input  logic              dflt_we,
    input  logic [DATA_W-1:0] dflt_data,
    input  logic              flag_clr,
    input  logic              req,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              out_left_dflt,
    output logic              out_right_dflt,
    output logic              left_full,
    output logic              left_empty,
    output logic              right_full,
    output logic              right_empty,
    output logic              ovf_left,
    output logic              ovf_right,
    output logic              unf_left,
    output logic              unf_right
);
    logic [NUM_CH-1:0]             wr_en;
    logic [NUM_CH-1:0][DATA_W-1:0] wr_raw, wr_code, head, out_data;
    logic [NUM_CH-1:0]             full, empty, pop, drop, miss, out_dflt, ovf, unf;

    assign wr_en[CH_LEFT]   = wr_left_en;
    assign wr_en[CH_RIGHT]  = wr_right_en;
    assign wr_raw[CH_LEFT]  = wr_left_data;
    assign wr_raw[CH_RIGHT] = wr_right_data;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            sbuf_fmt #(.DATA_W(DATA_W)) i_fmt (
                .din        (wr_raw[c]),
                .signed_sel (fmt_signed),
                .dout       (wr_code[c])
            );
            sbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (wr_en[c]),
                .din       (wr_code[c]),
                .pop       (pop[c]),
                .head      (head[c]),
                .full      (full[c]),
                .empty     (empty[c]),
                .push_drop (drop[c]),
                .pop_miss  (miss[c])
            );
        end
    endgenerate

    sbuf_seq #(.DATA_W(DATA_W), .DFLT_RESET(DFLT_RESET)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .dflt_we   (dflt_we),
        .dflt_din  (dflt_data),
        .head      (head),
        .empty     (empty),
        .pop       (pop),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_dflt  (out_dflt)
    );

    sbuf_flags #(.NUM_CH(NUM_CH)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flag_clr),
        .set_ovf (drop),
        .set_unf (miss),
        .ovf     (ovf),
        .unf     (unf)
    );

    assign out_left       = out_data[CH_LEFT];
    assign out_right      = out_data[CH_RIGHT];
    assign out_left_dflt  = out_dflt[CH_LEFT];
    assign out_right_dflt = out_dflt[CH_RIGHT];
    assign left_full      = full[CH_LEFT];
    assign left_empty     = empty[CH_LEFT];
    assign right_full     = full[CH_RIGHT];
    assign right_empty    = empty[CH_RIGHT];
    assign ovf_left       = ovf[CH_LEFT];
    assign ovf_right      = ovf[CH_RIGHT];
    assign unf_left       = unf[CH_LEFT];
    assign unf_right      = unf[CH_RIGHT];
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              flag_clr,
    input logic              wr_left_en,
    input logic              wr_right_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              out_left_dflt,
    input logic              out_right_dflt,
    input logic              left_full,
    input logic              left_empty,
    input logic              right_full,
    input logic              right_empty,
    input logic              ovf_left,
    input logic              ovf_right,
    input logic              unf_left,
    input logic              unf_right
);
    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid);

    // R4
    left_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !left_empty) |=> !out_left_dflt);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !out_valid);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(out_left) && $stable(out_right)
                  && $stable(out_left_dflt) && $stable(out_right_dflt)));

    // R5
    left_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && left_empty) |=> (unf_left && out_left_dflt));

    // R5
    right_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && right_empty) |=> (unf_right && out_right_dflt));

    // R3
    left_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_left_en && left_full && !req) |=> (ovf_left && left_full));

    // R3
    right_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_right_en && right_full && !req) |=> (ovf_right && right_full));

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !req && !wr_left_en && !wr_right_en)
        |=> !(ovf_left || ovf_right || unf_left || unf_right));

    // R2
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(left_full && left_empty) && !(right_full && right_empty));
endmodule

bind stereo_sample_buffer sbuf_chk #(.DATA_W(DATA_W)) i_sbuf_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req            (req),
    .flag_clr       (flag_clr),
    .wr_left_en     (wr_left_en),
    .wr_right_en    (wr_right_en),
    .out_valid      (out_valid),
    .out_left       (out_left),
    .out_right      (out_right),
    .out_left_dflt  (out_left_dflt),
    .out_right_dflt (out_right_dflt),
    .left_full      (left_full),
    .left_empty     (left_empty),
    .right_full     (right_full),
    .right_empty    (right_empty),
    .ovf_left       (ovf_left),
    .ovf_right      (ovf_right),
    .unf_left       (unf_left),
    .unf_right      (unf_right)
);

// File: tb/test_stereo_sample_buffer.sv
module test_stereo_sample_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_left_en = 1'b0, wr_right_en = 1'b0;
    logic [15:0] wr_left_data = '0, wr_right_data = '0;
    logic        fmt_signed = 1'b0, dflt_we = 1'b0, flag_clr = 1'b0, req = 1'b0;
    logic [15:0] dflt_data = '0;
    logic        out_valid, out_left_dflt, out_right_dflt;
    logic [15:0] out_left, out_right;
    logic        left_full, left_empty, right_full, right_empty;
    logic        ovf_left, ovf_right, unf_left, unf_right;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stereo_sample_buffer i_stereo_sample_buffer (
        .clk(clk), .rst_n(rst_n),
        .wr_left_en(wr_left_en), .wr_left_data(wr_left_data),
        .wr_right_en(wr_right_en), .wr_right_data(wr_right_data),
        .fmt_signed(fmt_signed), .dflt_we(dflt_we), .dflt_data(dflt_data),
        .flag_clr(flag_clr), .req(req),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .out_left_dflt(out_left_dflt), .out_right_dflt(out_right_dflt),
        .left_full(left_full), .left_empty(left_empty),
        .right_full(right_full), .right_empty(right_empty),
        .ovf_left(ovf_left), .ovf_right(ovf_right),
        .unf_left(unf_left), .unf_right(unf_right)
    );

    // vector: wl_en wl_d wr_en wr_d fmt req | exp_valid exp_l exp_r exp_ldf exp_rdf
    localparam int VW = 71;
    localparam int NV = 9;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1,16'h1111,1'b1,16'h2222,1'b0,1'b0, 1'b0,16'h0000,16'h0000,1'b0,1'b0},
        {1'b1,16'h3333,1'b0,16'h0000,1'b1,1'b0, 1'b0,16'h0000,16'h0000,1'b0,1'b0},
        {1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h1111,16'h2222,1'b0,1'b0},
        {1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'hB333,16'h8000,1'b0,1'b1},
        {1'b0,16'h0000,1'b1,16'h7FFF,1'b1,1'b1, 1'b1,16'h8000,16'h8000,1'b1,1'b1},
        {1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0, 1'b0,16'h0000,16'h0000,1'b0,1'b0},
        {1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h8000,16'hFFFF,1'b1,1'b0},
        {1'b1,16'h0001,1'b1,16'hFFFF,1'b0,1'b1, 1'b1,16'h8000,16'h8000,1'b1,1'b1},
        {1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1, 1'b1,16'h0001,16'hFFFF,1'b0,1'b0}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        wr_left_en = 1'b0; wr_right_en = 1'b0; fmt_signed = 1'b0;
        dflt_we = 1'b0; flag_clr = 1'b0; req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic wr_left(input logic [15:0] d, input logic sgn);
        wr_left_en = 1'b1; wr_left_data = d; fmt_signed = sgn;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 empties", {30'd0, left_empty, right_empty}, 32'd3);
        chk("R1 fulls", {30'd0, left_full, right_full}, 32'd0);
        chk("R1 flags", {28'd0, ovf_left, ovf_right, unf_left, unf_right}, 32'd0);
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 out", {out_left, out_right}, 32'h8000_8000);

        // table walk: R4 order, R5 default, R7 conversion, R10 valid drop
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            wr_left_en = v[70]; wr_left_data = v[69:54];
            wr_right_en = v[53]; wr_right_data = v[52:37];
            fmt_signed = v[36]; req = v[35];
            tick();
            chk("R4/R10 table valid", {31'd0, out_valid}, {31'd0, v[34]});
            if (v[34]) begin
                chk("R4/R7 table data", {out_left, out_right}, {v[33:18], v[17:2]});
                chk("R5 table dflt", {30'd0, out_left_dflt, out_right_dflt}, {30'd0, v[1:0]});
            end
        end

        do_reset();
        // R2 fill to DEPTH
        for (int k = 0; k < 4; k++) begin
            chk("R2 not full yet", {31'd0, left_full}, 32'd0);
            wr_left(16'hA000 + 16'(k), 1'b0);
            tick();
        end
        chk("R2 full", {30'd0, left_full, left_empty}, 32'd2);
        // R3 dropped write
        wr_left(16'hAFFF, 1'b0);
        tick();
        chk("R3 ovf set", {31'd0, ovf_left}, 32'd1);
        chk("R3 still full", {31'd0, left_full}, 32'd1);
        // R9 write on full with request
        wr_left(16'hA004, 1'b0); req = 1'b1;
        tick();
        chk("R9 first out", {16'd0, out_left}, 32'h0000_A000);
        chk("R9 still full", {31'd0, left_full}, 32'd1);
        for (int k = 1; k <= 4; k++) begin
            req = 1'b1;
            tick();
            chk("R4 fifo order", {16'd0, out_left}, {16'd0, 16'hA000 + 16'(k)});
        end
        chk("R2 empty after drain", {31'd0, left_empty}, 32'd1);
        req = 1'b1;
        tick();
        chk("R5 default on empty", {15'd0, out_left_dflt, out_left}, 32'h0001_8000);
        chk("R5 unf set", {31'd0, unf_left}, 32'd1);

        // R8 set wins over clear, then clear alone
        flag_clr = 1'b1; req = 1'b1;
        tick();
        chk("R8 unf set wins", {31'd0, unf_left}, 32'd1);
        chk("R8 ovf cleared", {31'd0, ovf_left}, 32'd0);
        flag_clr = 1'b1;
        tick();
        chk("R8 all cleared", {28'd0, ovf_left, ovf_right, unf_left, unf_right}, 32'd0);

        // R6 default register, not format converted
        dflt_we = 1'b1; dflt_data = 16'h1234; fmt_signed = 1'b1;
        tick();
        req = 1'b1;
        tick();
        chk("R6 new default", {out_left, out_right}, 32'h1234_1234);

        // R7 signed extremes
        wr_left(16'h8000, 1'b1); wr_right_en = 1'b1; wr_right_data = 16'h0000;
        tick();
        wr_left(16'h7FFF, 1'b1); wr_right_en = 1'b1; wr_right_data = 16'hFFFF;
        tick();
        req = 1'b1;
        tick();
        chk("R7 min and mid", {out_left, out_right}, 32'h0000_8000);
        req = 1'b1;
        tick();
        chk("R7 max and below mid", {out_left, out_right}, 32'hFFFF_7FFF);
        // R10 hold
        tick();
        chk("R10 valid low", {31'd0, out_valid}, 32'd0);
        chk("R10 outputs held", {out_left, out_right}, 32'hFFFF_7FFF);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule